// File: doc/BRIEF.md
# Carrier Sense and Collision Generator

This block produces the media-independent-interface carrier sense and collision outputs for one physical-layer port. It takes the transmit enable from the MAC, a receive-activity flag from the line receiver, the duplex setting, the operating speed, a jabber-expired flag from the jabber timer, and two mode controls. Each mode control has both a pin and a management register bit, and the two sources are ORed. One control limits carrier sense to receive activity. The other selects the serial 10 Mb/s data path.

Carrier sense normally follows activity in either direction. When receive-only sensing is selected, or when the port runs full duplex, it follows receive activity alone. In half duplex the collision output is high while the port is transmitting and receiving at the same time. In full duplex the collision output is held low. When the port uses the serial path at 10 Mb/s, the collision output is reused to report that the jabber timer has expired. A parameter can turn off that reuse.

Both outputs are combinational. They have no clock and no reset, so they follow their inputs within the same cycle.

Top module: `cs_col_gen`

## Requirements
- R1: In half duplex, outside serial 10 Mb/s operation, col_o equals tx_en_i AND rx_act_i.
- R2: In full duplex (full_dup_i=1), outside serial 10 Mb/s operation, col_o is 0 for every combination of tx_en_i and rx_act_i.
- R3: In half duplex with the effective receive-only select low, crs_o equals tx_en_i OR rx_act_i.
- R4: With the effective receive-only select high, crs_o equals rx_act_i, and tx_en_i has no effect on it.
- R5: The effective receive-only select is crs_rx_only_pin_i OR crs_rx_only_reg_i, so either source alone selects receive-only sensing.
- R6: In full duplex, crs_o equals rx_act_i whatever the receive-only select value.
- R7: Whenever col_o reports a collision (outside serial 10 Mb/s operation), crs_o is also 1.
- R8: In serial 10 Mb/s operation (serial mode selected and speed100_i=0), col_o equals jabber_exp_i, and tx_en_i, rx_act_i and full_dup_i have no effect on it.
- R9: Serial mode is selected by serial_pin_i OR serial_reg_i. At 100 Mb/s (speed100_i=1), serial mode has no effect on col_o.
- R10: Outside serial 10 Mb/s operation, jabber_exp_i has no effect on col_o or crs_o.
- R11: With parameter JAB_REUSE=0, col_o follows R1 and R2 in every mode and never reflects jabber_exp_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_act_i | input | 1 | Receive activity detected on the line |
| full_dup_i | input | 1 | 1 selects full duplex, 0 selects half duplex |
| crs_rx_only_pin_i | input | 1 | Receive-only carrier sense select, pin source |
| crs_rx_only_reg_i | input | 1 | Receive-only carrier sense select, register source |
| serial_pin_i | input | 1 | Serial 10 Mb/s path select, pin source |
| serial_reg_i | input | 1 | Serial 10 Mb/s path select, register source |
| speed100_i | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| jabber_exp_i | input | 1 | Jabber timer expired flag |
| crs_o | output | 1 | Carrier sense |
| col_o | output | 1 | Collision, or jabber expiry in serial 10 Mb/s operation |

## Verification
The bench builds two copies of the block: `uut` with the default JAB_REUSE=1, and a second copy with JAB_REUSE=0. Each copy is driven through all 512 combinations of its nine inputs. Together the two copies reach both generate variants of the collision path. The exhaustive sweep covers every pairing of duplex, the two OR-combined selects and speed, including the cases where only one source of a select is high. A set of directed cases then names each requirement at its boundaries.

// File: rtl/csc_pkg.sv
package csc_pkg;

  // Operating mode once the pin and register sources have been merged
  typedef struct packed {
    logic rx_only;   // carrier sense limited to receive activity
    logic fdx;       // full duplex
    logic ser10;     // serial path at 10 Mb/s
  } csc_mode_t;

  localparam int unsigned CSC_MODE_W = $bits(csc_mode_t);

endpackage

// File: rtl/csc_mode_dec.sv
module csc_mode_dec
  import csc_pkg::*;
(
  input  logic      rx_only_pin_i,
  input  logic      rx_only_reg_i,
  input  logic      serial_pin_i,
  input  logic      serial_reg_i,
  input  logic      speed100_i,
  input  logic      full_dup_i,
  output csc_mode_t mode_o
);

  logic serial_sel;

  always_comb begin
    serial_sel     = serial_pin_i | serial_reg_i;
    mode_o.fdx     = full_dup_i;
    // full duplex forces receive-only sensing
    mode_o.rx_only = rx_only_pin_i | rx_only_reg_i | full_dup_i;
    mode_o.ser10   = serial_sel & ~speed100_i;
  end

endmodule

// File: rtl/csc_crs_path.sv
module csc_crs_path
  import csc_pkg::*;
(
  input  csc_mode_t mode_i,
  input  logic      tx_en_i,
  input  logic      rx_act_i,
  output logic      crs_o
);

  always_comb begin
    if (mode_i.rx_only) crs_o = rx_act_i;
    else                crs_o = rx_act_i | tx_en_i;
  end

endmodule

// File: rtl/csc_col_path.sv
module csc_col_path
  import csc_pkg::*;
#(
  parameter bit JAB_REUSE = 1'b1
) (
  input  csc_mode_t mode_i,
  input  logic      tx_en_i,
  input  logic      rx_act_i,
  input  logic      jabber_exp_i,
  output logic      col_o
);

  logic overlap;

  always_comb begin
    overlap = tx_en_i & rx_act_i & ~mode_i.fdx;
  end

  generate
    if (JAB_REUSE) begin : g_jab
      always_comb begin
        col_o = mode_i.ser10 ? jabber_exp_i : overlap;
      end
    end else begin : g_nojab
      always_comb begin
        col_o = overlap;
      end
    end
  endgenerate

endmodule

// File: rtl/cs_col_gen.sv
module cs_col_gen
  import csc_pkg::*;
#(
  parameter bit JAB_REUSE = 1'b1
) (
  input  logic tx_en_i,
  input  logic rx_act_i,
  input  logic full_dup_i,
  input  logic crs_rx_only_pin_i,
  input  logic crs_rx_only_reg_i,
  input  logic serial_pin_i,
  input  logic serial_reg_i,
  input  logic speed100_i,
  input  logic jabber_exp_i,
  output logic crs_o,
  output logic col_o
);

  csc_mode_t mode;

  csc_mode_dec u_dec (
    .rx_only_pin_i (crs_rx_only_pin_i),
    .rx_only_reg_i (crs_rx_only_reg_i),
    .serial_pin_i  (serial_pin_i),
    .serial_reg_i  (serial_reg_i),
    .speed100_i    (speed100_i),
    .full_dup_i    (full_dup_i),
    .mode_o        (mode)
  );

  csc_crs_path u_crs (
    .mode_i   (mode),
    .tx_en_i  (tx_en_i),
    .rx_act_i (rx_act_i),
    .crs_o    (crs_o)
  );

  csc_col_path #(.JAB_REUSE(JAB_REUSE)) u_col (
    .mode_i       (mode),
    .tx_en_i      (tx_en_i),
    .rx_act_i     (rx_act_i),
    .jabber_exp_i (jabber_exp_i),
    .col_o        (col_o)
  );

endmodule

// File: rtl/cs_col_gen_chk.sv
module cs_col_gen_chk #(
  parameter bit JAB_REUSE = 1'b1
) (
  input logic tx_en_i,
  input logic rx_act_i,
  input logic full_dup_i,
  input logic crs_rx_only_pin_i,
  input logic crs_rx_only_reg_i,
  input logic serial_pin_i,
  input logic serial_reg_i,
  input logic speed100_i,
  input logic jabber_exp_i,
  input logic crs_o,
  input logic col_o
);

  logic in_ser10;

  always_comb begin
    in_ser10 = JAB_REUSE && (serial_pin_i || serial_reg_i) && !speed100_i;

    // R1 / R11: half-duplex collision needs both directions active
    if (!in_ser10 && !full_dup_i)
      p_col_overlap_r1: assert (col_o == (tx_en_i && rx_act_i));
    // R2: no collision in full duplex
    if (!in_ser10 && full_dup_i)
      p_col_quiet_fdx_r2: assert (!col_o);
    // R4 / R6: receive-only sensing
    if (crs_rx_only_pin_i || crs_rx_only_reg_i || full_dup_i)
      p_crs_rx_only_r4: assert (crs_o == rx_act_i);
    // R3: either direction in half duplex
    if (!crs_rx_only_pin_i && !crs_rx_only_reg_i && !full_dup_i)
      p_crs_either_r3: assert (crs_o == (tx_en_i || rx_act_i));
    // R7: carrier held through a collision
    if (!in_ser10 && col_o)
      p_crs_in_col_r7: assert (crs_o);
    // R8: jabber shown in serial 10 Mb/s
    if (in_ser10)
      p_col_jabber_r8: assert (col_o == jabber_exp_i);
  end

endmodule

bind cs_col_gen cs_col_gen_chk #(.JAB_REUSE(JAB_REUSE)) u_chk (
  .tx_en_i           (tx_en_i),
  .rx_act_i          (rx_act_i),
  .full_dup_i        (full_dup_i),
  .crs_rx_only_pin_i (crs_rx_only_pin_i),
  .crs_rx_only_reg_i (crs_rx_only_reg_i),
  .serial_pin_i      (serial_pin_i),
  .serial_reg_i      (serial_reg_i),
  .speed100_i        (speed100_i),
  .jabber_exp_i      (jabber_exp_i),
  .crs_o             (crs_o),
  .col_o             (col_o)
);

// File: tb/cs_col_gen_test.sv
`timescale 1ns/1ps
module cs_col_gen_test;

  logic clk;
  logic rst_n;
  logic tx, rx, fdx, cpin, creg, spin, sreg, s100, jab;
  logic crs_a, col_a, crs_b, col_b;
  int   checks;
  int   errors;
  bit   done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  cs_col_gen uut (
    .tx_en_i(tx), .rx_act_i(rx), .full_dup_i(fdx),
    .crs_rx_only_pin_i(cpin), .crs_rx_only_reg_i(creg),
    .serial_pin_i(spin), .serial_reg_i(sreg), .speed100_i(s100),
    .jabber_exp_i(jab), .crs_o(crs_a), .col_o(col_a)
  );

  cs_col_gen #(.JAB_REUSE(1'b0)) uut_nojab (
    .tx_en_i(tx), .rx_act_i(rx), .full_dup_i(fdx),
    .crs_rx_only_pin_i(cpin), .crs_rx_only_reg_i(creg),
    .serial_pin_i(spin), .serial_reg_i(sreg), .speed100_i(s100),
    .jabber_exp_i(jab), .crs_o(crs_b), .col_o(col_b)
  );

  // Behavioural reference, written rule by rule from the requirements
  function automatic int ref_crs(int t, int r, int f, int cp, int cr);
    int sel = 0;
    if (cp != 0) sel = 1;
    if (cr != 0) sel = 1;
    if (f != 0)  return r;
    if (sel != 0) return r;
    if (t + r > 0) return 1;
    return 0;
  endfunction

  function automatic int ref_col(int reuse, int t, int r, int f, int sp,
                                 int sr, int s, int j);
    int ser = 0;
    if (sp == 1 || sr == 1) ser = 1;
    if (reuse == 1 && ser == 1 && s == 0) return j;
    if (f == 1) return 0;
    if (t == 1 && r == 1) return 1;
    return 0;
  endfunction

  task automatic apply(input int v);
    @(posedge clk);
    {jab, s100, sreg, spin, creg, cpin, fdx, rx, tx} = v[8:0];
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (inputs jab=%0b s100=%0b sreg=%0b spin=%0b creg=%0b cpin=%0b fdx=%0b rx=%0b tx=%0b)",
               req, act, exp, jab, s100, sreg, spin, creg, cpin, fdx, rx, tx);
    end
  endtask

  function automatic string tag_col(int reuse);
    if (reuse == 1 && (spin || sreg) && !s100) return "R8";
    if (reuse == 0) return "R11";
    if (fdx) return "R2";
    return "R1";
  endfunction

  function automatic string tag_crs();
    if (fdx) return "R6";
    if (cpin || creg) return "R4";
    return "R3";
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    {jab, s100, sreg, spin, creg, cpin, fdx, rx, tx} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: idle inputs give idle outputs
    check("R3", int'(crs_a), 0);
    check("R1", int'(col_a), 0);
    rst_n = 1'b1;

    // exhaustive sweep, reference compared every clock
    for (int v = 0; v < 512; v++) begin
      apply(v);
      check(tag_crs(), int'(crs_a), ref_crs(tx, rx, fdx, cpin, creg));
      check(tag_col(1), int'(col_a), ref_col(1, tx, rx, fdx, spin, sreg, s100, jab));
      check(tag_crs(), int'(crs_b), ref_crs(tx, rx, fdx, cpin, creg));
      check(tag_col(0), int'(col_b), ref_col(0, tx, rx, fdx, spin, sreg, s100, jab));
      if (!((spin || sreg) && !s100) && col_a) check("R7", int'(crs_a), 1);
      if (!((spin || sreg) && !s100)) begin
        // R10: jabber flag ignored outside serial 10 Mb/s
        check("R10", int'(col_a), ref_col(1, tx, rx, fdx, spin, sreg, s100, 0));
      end
    end

    // directed corner cases (bit order: jab s100 sreg spin creg cpin fdx rx tx)
    apply(9'b0_1_0_0_0_0_0_1_1); check("R1", int'(col_a), 1);
    apply(9'b0_1_0_0_0_0_1_1_1); check("R2", int'(col_a), 0);
    apply(9'b0_1_0_0_0_0_0_0_1); check("R3", int'(crs_a), 1);
    apply(9'b0_1_0_0_0_1_0_0_1); check("R5", int'(crs_a), 0);
    apply(9'b0_1_0_0_1_0_0_0_1); check("R5", int'(crs_a), 0);
    apply(9'b0_1_0_0_1_0_0_1_1); check("R4", int'(crs_a), 1);
    apply(9'b0_1_0_0_0_0_1_0_1); check("R6", int'(crs_a), 0);
    apply(9'b0_1_0_0_0_0_0_1_1); check("R7", int'(crs_a), 1);
    apply(9'b1_0_0_1_0_0_0_0_0); check("R8", int'(col_a), 1);
    apply(9'b0_0_1_0_0_0_0_1_1); check("R8", int'(col_a), 0);
    apply(9'b1_0_1_0_0_0_1_0_0); check("R9", int'(col_a), 1);
    apply(9'b0_1_1_1_0_0_0_1_1); check("R9", int'(col_a), 1);
    apply(9'b1_1_0_0_0_0_0_0_0); check("R10", int'(col_a), 0);
    apply(9'b1_0_0_1_0_0_0_0_0); check("R11", int'(col_b), 0);
    apply(9'b0_0_0_1_0_0_0_1_1); check("R11", int'(col_b), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule